// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block sits beside the main sequencer of a simple SDRAM controller and puts the memory into self-refresh on its own. It measures how long the memory has gone without an access or an auto-refresh. The measurement is a saturating idle counter that advances once per clock while the block is awake. When software has enabled the feature and the counter matches the programmed count, the block issues a precharge-all, then the self-refresh command with CKE falling, and then holds NOP with CKE low. While self-refresh lasts it can also gate the SDRAM clock output, under the control of a configuration bit.

An access request that arrives during self-refresh raises CKE. The block then holds NOP for a parameterised recovery interval, and only after that does it report ready to the main sequencer, which then performs the access. An auto-refresh or an accepted access clears the idle counter. An active-low awake flag mirrors the self-refresh condition for software.

The idle comparator stays armed for the first two cycles of exit recovery. A programmed count of 0 or 1 therefore matches again during recovery, and the block drops straight back into self-refresh. With the enable still set, the pending access is never released. The only way out is to clear the enable.

Top module: `sdr_selfref_ctl`

## Requirements
- R1: During and after synchronous reset the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0), and sd_cke=1, acc_rdy=1, sts_awake=1 and sd_clk_en=1.
- R2: While cfg_sr_en=0, no precharge-all is issued and sd_cke stays 1.
- R3: With the enable set and programmed count C, the precharge-all appears right after the (C+1)-th rising clock edge that follows the edge at which an auto-refresh strobe or an accepted access was sampled, provided no further request arrives in between.
- R4: Every auto-refresh strobe and every accepted access (acc_req=1 while acc_rdy=1) restarts the idle count from zero, so requests spaced at most C edges apart prevent entry.
- R5: The entry sequence takes three consecutive cycles. First comes precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1, cke=1). Next is self-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=0). NOP with cke=0 follows until an access request.
- R6: sts_awake reads 0 exactly in the cycles where sd_cke is 0, and 1 otherwise.
- R7: sd_clk_en equals cfg_clk_run during the NOP cycles of self-refresh, and is 1 in every other cycle, including the self-refresh command cycle.
- R8: acc_req=1 during self-refresh raises sd_cke after the next edge. NOP then holds with acc_rdy=0 for exactly TRP_CYC cycles, after which acc_rdy returns to 1.
- R9: acc_rdy is 0 from the precharge-all cycle through the last recovery cycle. Whenever acc_rdy is 1, the pins carry NOP with sd_cke=1.
- R10: With the enable set and a programmed count of 0 or 1, an access request made during self-refresh causes repeated re-entry (further precharge-all commands), and acc_rdy never returns to 1.
- R11: Clearing cfg_sr_en while an access request is held lets the block complete exit recovery and raise acc_rdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sr_en | input | 1 | Enables automatic self-refresh entry |
| cfg_idle_cnt | input | CNT_W | Idle cycles before entry (valid 2..15) |
| cfg_clk_run | input | 1 | 1 keeps the SDRAM clock running during self-refresh |
| acc_req | input | 1 | Access request level from the main sequencer |
| arf_req | input | 1 | Auto-refresh issue strobe from the main sequencer |
| acc_rdy | output | 1 | Block is awake and the access may be performed |
| sts_awake | output | 1 | Status, 0 while in self-refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Address bit 10 (all-bank select for precharge) |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_clk_en | output | 1 | Gate for the SDRAM clock output |

## Verification
The hardest situation to reach is the lock-up loop, because it needs an out-of-range count. It also needs an access request held across a self-refresh exit and the re-arming window of recovery. The bench programs a count of 1, lets the block fall asleep, and holds the request for forty cycles. It then checks that ready never returns and that precharge-all recurs. It next clears the enable with the request still held, to show that the loop releases. Exact entry timing is checked by starting every interval from a single auto-refresh pulse, which fixes the counter's start edge.

// File: rtl/sdr_sr_pkg.sv
package sdr_sr_pkg;

  typedef enum logic [2:0] {
    ST_NORM,
    ST_PALL,
    ST_SELF,
    ST_SLEEP,
    ST_WAKE
  } sr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam sd_cmd_t CMD_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam sd_cmd_t CMD_SELF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

  function automatic sd_cmd_t cmd_of(sr_state_e st);
    case (st)
      ST_PALL: cmd_of = CMD_PALL;
      ST_SELF: cmd_of = CMD_SELF;
      default: cmd_of = CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sr_idle_counter.sv
module sr_idle_counter #(
  parameter int CNT_W     = 4,
  parameter int EARLY_WIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             hit,
  output logic             early
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(EARLY_WIN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit   = (cnt_q == limit);
  assign early = (cnt_q < WIN_LIM);

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

  assert_hold_asleep_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/sr_recovery_timer.sv
module sr_recovery_timer #(
  parameter int TRP_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic done
);

  localparam int RC_W = $clog2(TRP_CYC + 1);
  localparam logic [RC_W-1:0] LAST = RC_W'(TRP_CYC - 1);

  logic [RC_W-1:0] rc_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      rc_q <= '0;
    end else if (rc_q != LAST) begin
      rc_q <= rc_q + 1'b1;
    end
  end

  assign done = active && (rc_q == LAST);

  assert_rc_bound_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> (rc_q <= LAST));

  assert_rc_starts_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> (rc_q == '0));

endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sdr_sr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      clk_run,
  input  logic      acc_req,
  input  logic      arf_req,
  input  logic      cnt_hit,
  input  logic      cnt_early,
  input  logic      rec_done,
  output sr_state_e state,
  output logic      cnt_run,
  output logic      cnt_restart,
  output sd_cmd_t   cmd,
  output logic      cke,
  output logic      rdy,
  output logic      awake,
  output logic      clk_en
);

  sr_state_e state_q, state_nxt;
  sd_cmd_t   cmd_q;
  logic      cke_q, rdy_q, awake_q, clk_en_q;
  logic      asleep_nxt;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_NORM:  if (!acc_req && !arf_req && en && cnt_hit) state_nxt = ST_PALL;
      ST_PALL:  state_nxt = ST_SELF;
      ST_SELF:  state_nxt = ST_SLEEP;
      ST_SLEEP: if (acc_req) state_nxt = ST_WAKE;
      ST_WAKE: begin
        if (en && cnt_hit && cnt_early) state_nxt = ST_PALL;
        else if (rec_done)              state_nxt = ST_NORM;
      end
      default:  state_nxt = ST_NORM;
    endcase
  end

  assign asleep_nxt = (state_nxt == ST_SELF) || (state_nxt == ST_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_NORM;
      cmd_q    <= CMD_NOP;
      cke_q    <= 1'b1;
      rdy_q    <= 1'b1;
      awake_q  <= 1'b1;
      clk_en_q <= 1'b1;
    end else begin
      state_q  <= state_nxt;
      cmd_q    <= cmd_of(state_nxt);
      cke_q    <= !asleep_nxt;
      rdy_q    <= (state_nxt == ST_NORM);
      awake_q  <= !asleep_nxt;
      clk_en_q <= (state_nxt == ST_SLEEP) ? clk_run : 1'b1;
    end
  end

  assign cnt_run     = (state_q == ST_NORM) || (state_q == ST_WAKE);
  assign cnt_restart = ((state_q == ST_NORM) && (acc_req || arf_req)) ||
                       ((state_q == ST_SLEEP) && acc_req);

  assign state  = state_q;
  assign cmd    = cmd_q;
  assign cke    = cke_q;
  assign rdy    = rdy_q;
  assign awake  = awake_q;
  assign clk_en = clk_en_q;

  assert_no_entry_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NORM && !en) |=> (cmd_q != CMD_PALL));

  assert_self_after_pall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_q) |-> ($past(cmd_q) == CMD_PALL && cmd_q == CMD_SELF));

  assert_asleep_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
    !awake_q |-> (!rdy_q && !cke_q));

  assert_clk_gate_sleep_R7: assert property (@(posedge clk) disable iff (rst)
    !clk_en_q |-> (!cke_q && cmd_q == CMD_NOP));

  assert_wake_nop_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_q) |-> (cmd_q == CMD_NOP && !rdy_q));

  assert_rdy_idle_R9: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> (cke_q && cmd_q == CMD_NOP));

endmodule

// File: rtl/sdr_selfref_ctl.sv
module sdr_selfref_ctl
  import sdr_sr_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int TRP_CYC   = 3,
  parameter int EARLY_WIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_sr_en,
  input  logic [CNT_W-1:0] cfg_idle_cnt,
  input  logic             cfg_clk_run,
  input  logic             acc_req,
  input  logic             arf_req,
  output logic             acc_rdy,
  output logic             sts_awake,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_a10,
  output logic             sd_cke,
  output logic             sd_clk_en
);

  sr_state_e state;
  sd_cmd_t   cmd;
  logic      cnt_run, cnt_restart, cnt_hit, cnt_early, rec_done;

  sr_idle_counter #(
    .CNT_W     (CNT_W),
    .EARLY_WIN (EARLY_WIN)
  ) idle_i (
    .clk     (clk),
    .rst     (rst),
    .run     (cnt_run),
    .restart (cnt_restart),
    .limit   (cfg_idle_cnt),
    .hit     (cnt_hit),
    .early   (cnt_early)
  );

  sr_recovery_timer #(
    .TRP_CYC (TRP_CYC)
  ) recov_i (
    .clk    (clk),
    .rst    (rst),
    .active (state == ST_WAKE),
    .done   (rec_done)
  );

  sr_seq_fsm fsm_i (
    .clk         (clk),
    .rst         (rst),
    .en          (cfg_sr_en),
    .clk_run     (cfg_clk_run),
    .acc_req     (acc_req),
    .arf_req     (arf_req),
    .cnt_hit     (cnt_hit),
    .cnt_early   (cnt_early),
    .rec_done    (rec_done),
    .state       (state),
    .cnt_run     (cnt_run),
    .cnt_restart (cnt_restart),
    .cmd         (cmd),
    .cke         (sd_cke),
    .rdy         (acc_rdy),
    .awake       (sts_awake),
    .clk_en      (sd_clk_en)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;
  assign sd_a10   = cmd.a10;

  initial begin
    assert_trp_min_R8: assert (TRP_CYC >= EARLY_WIN && EARLY_WIN == 2)
      else $error("TRP_CYC must cover the re-arm window");
  end

endmodule

// File: tb/sdr_selfref_ctl_tb_top.sv
`timescale 1ns/1ps
module sdr_selfref_ctl_tb_top;

  localparam int TRP = 3;

  typedef struct {
    logic [8:0] v;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, run = 1'b1, acc = 1'b0, arf = 1'b0;
  logic [3:0] cfg = 4'd3;
  logic       acc_rdy, sts_awake, cs_n, ras_n, cas_n, we_n, a10, cke, clk_en;

  exp_t q[$];
  int   vec = 0;
  int   miss = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  sdr_selfref_ctl #(.CNT_W(4), .TRP_CYC(TRP), .EARLY_WIN(2)) dut_i (
    .clk(clk), .rst(rst), .cfg_sr_en(en), .cfg_idle_cnt(cfg), .cfg_clk_run(run),
    .acc_req(acc), .arf_req(arf), .acc_rdy(acc_rdy), .sts_awake(sts_awake),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_a10(a10), .sd_cke(cke), .sd_clk_en(clk_en)
  );

  // packing: cs ras cas we a10 cke rdy sts clken
  function automatic logic [8:0] pk(logic c, r, ca, w, a, k, rd, s, ce);
    return {c, r, ca, w, a, k, rd, s, ce};
  endfunction
  localparam logic [8:0] E_NORM = 9'b0_1_1_1_0_1_1_1_1;
  localparam logic [8:0] E_PALL = 9'b0_0_1_0_1_1_0_1_1;
  localparam logic [8:0] E_SELF = 9'b0_0_0_1_0_0_0_0_1;
  localparam logic [8:0] E_WAKE = 9'b0_1_1_1_0_1_0_1_1;
  function automatic logic [8:0] e_sleep(logic r);
    return {8'b0_1_1_1_0_0_0_0, r};
  endfunction

  function automatic logic [8:0] observed();
    return pk(cs_n, ras_n, cas_n, we_n, a10, cke, acc_rdy, sts_awake, clk_en);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: compares one expected item per clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      vec++;
      if (observed() !== it.v) begin
        miss++;
        $display("FAIL %s actual %b expected %b", it.tag, observed(), it.v);
      end
    end
  end

  // driver: drive inputs at the falling edge and push what must follow the next rising edge
  task automatic step(input logic e, input logic f, input logic a, input logic [8:0] x, input string tag);
    exp_t it;
    @(negedge clk);
    en = e; arf = f; acc = a;
    it.v = x; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sleep_and_wake(input logic r);
    step(1, 0, 0, E_PALL, "R5");
    step(1, 0, 0, E_SELF, "R5");
    for (int i = 0; i < 3; i++) step(1, 0, 0, e_sleep(r), "R7");
    for (int i = 0; i < TRP; i++) step(1, 0, 1, E_WAKE, "R8");
    step(1, 0, 1, E_NORM, "R9");
    step(1, 0, 1, E_NORM, "R9");
    step(0, 0, 0, E_NORM, "R9");
  endtask

  task automatic entry(input logic [3:0] c, input logic r);
    @(negedge clk);
    cfg = c; run = r;
    step(1, 1, 0, E_NORM, "R3");
    for (int i = 0; i < c; i++) step(1, 0, 0, E_NORM, "R3");
    sleep_and_wake(r);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    miss++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    // R1 reset values
    for (int i = 0; i < 3; i++) step(0, 0, 0, E_NORM, "R1");
    rst = 1'b0;
    // R2 disabled: no entry
    for (int i = 0; i < 20; i++) step(0, 0, 0, E_NORM, "R2");

    entry(4'd2, 1'b1);
    entry(4'd15, 1'b0);
    entry(4'd5, 1'b1);

    // R4: pulses every 4 edges with count 4 never reach entry
    @(negedge clk); cfg = 4'd4; run = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 0, E_NORM, "R4");
      for (int i = 0; i < 3; i++) step(1, 0, 0, E_NORM, "R4");
    end
    // an accepted access restarts the count too
    step(1, 0, 1, E_NORM, "R4");
    for (int i = 0; i < 4; i++) step(1, 0, 0, E_NORM, "R4");
    sleep_and_wake(1'b1);
    drain();

    // R10: count of 1 locks the block once woken
    @(negedge clk); cfg = 4'd1;
    step(1, 1, 0, E_NORM, "R3");
    step(1, 0, 0, E_NORM, "R3");
    step(1, 0, 0, E_PALL, "R5");
    step(1, 0, 0, E_SELF, "R5");
    step(1, 0, 0, e_sleep(1'b1), "R6");
    drain();
    begin
      int rdy_seen = 0;
      int pall_seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); acc = 1'b1;
        @(posedge clk); #2;
        if (acc_rdy) rdy_seen++;
        if (observed() == E_PALL) pall_seen++;
        chk(sts_awake == cke, "R6", sts_awake, cke);
      end
      chk(rdy_seen == 0, "R10", rdy_seen, 0);
      chk(pall_seen >= 3, "R10", pall_seen, 3);
    end

    // R11: clearing the enable releases the held access
    begin
      int got = 0;
      @(negedge clk); en = 1'b0;
      for (int i = 0; i < 12 && got == 0; i++) begin
        @(posedge clk); #2;
        if (acc_rdy) got = 1;
      end
      chk(got == 1, "R11", got, 1);
      chk(cke == 1'b1 && sts_awake == 1'b1, "R11", cke, 1);
    end
    @(negedge clk); acc = 1'b0; cfg = 4'd3;
    for (int i = 0; i < 6; i++) step(0, 0, 0, E_NORM, "R2");
    drain();
    finish_run();
  end

endmodule